// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous static memory with a small on-chip array. Its bus never needs a turnaround cycle. Every input is sampled on the rising clock edge. Write data does not arrive with its command: it follows one cycle later in flow-through mode and two cycles later in pipelined mode. Because of this, a read can follow a write, and a write can follow a read, on consecutive clocks with no idle slot between them. A read that hits an address whose write data has not yet reached the array is served from the in-flight data, merged byte by byte.

The mode input is static and is changed only while reset is held. In flow-through mode, read data appears in the cycle right after the edge that sampled the read. In pipelined mode it passes through an output register and appears one edge later. Three chip enables must all be active for a command to be taken. An advance input steps a four-beat burst, in either linear or interleaved order. The output enable and the sleep input act on the outputs without waiting for a clock. While sleep is high, new commands are ignored and the array keeps its contents.

Top module: `lwsram_core`

## Requirements
- R1: A command is taken only when sel_a_n=0, sel_b=1 and sel_c_n=0 with adv=0. Any other enable pattern with adv=0 is a deselect: no array write happens and no read data is presented.
- R2: In flow-through mode (flow_mode=1), a read sampled at edge k shows its data on dout with dout_vld=1 from edge k until edge k+1.
- R3: In pipelined mode (flow_mode=0), a read sampled at edge k shows its data from edge k+1 until edge k+2. dout_vld is 0 after edge k unless the command before the read was also a read.
- R4: In flow-through mode, the write data for a write sampled at edge k is taken from din at edge k+1.
- R5: In pipelined mode, the write data for a write sampled at edge k is taken from din at edge k+2.
- R6: Reads and writes may alternate on every clock. A read of an address whose write is still waiting for its data returns the new data.
- R7: bwe[i]=1 writes din bits [9i+8:9i] of byte i. A byte with bwe[i]=0 keeps its old value, and this holds in the in-flight read path too. bwe is sampled together with the command.
- R8: With burst_ilv=0, each cycle with adv=1 after an accepted command repeats that command's direction. The low two address bits become (start + n) mod 4, the upper bits stay fixed, and the fifth beat returns to the start address.
- R9: With burst_ilv=1, the low two address bits of beat n are start XOR n.
- R10: oe_n=1 forces dout to zero and dout_vld to 0 at once, with no clock edge needed. Clearing oe_n restores the held read data.
- R11: While sleep=1, commands are ignored and dout_vld is 0. The array contents are retained.
- R12: After reset, dout_vld=0 and dout=0, and no burst is in progress.
- R13: adv=1 after a deselected or sleeping cycle is itself a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_mode | input | 1 | 1 = flow-through reads, 0 = pipelined reads (static) |
| addr | input | ADDR_W | Command word address |
| wr_sel | input | 1 | 1 = write command, 0 = read command |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue the current burst with the next address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| bwe | input | BYTES | Per-byte write enables, sampled with the command |
| din | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Ignore commands and turn outputs off |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_vld | output | 1 | Read data on dout is valid |

## Verification
The hardest case to reach is a pipelined read of an address whose write command has been accepted but whose data has not yet reached the array. In that case the output register must take some bytes from the data bus on the same edge that commits them. The bench reaches it by issuing a partial-byte write, then a read of the same address on the next cycle, then placing the write data on din in the following cycle. It checks the merged word against a byte-wise model. A write-read-write-read run on distinct addresses covers direction changes with no dead cycles, and a five-beat burst shows the wrap back to the start address.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits of burst beat 'step'
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
    import lwsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_sel,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          adv,
    input  logic          burst_ilv,
    input  logic          sleep,
    input  logic [NB-1:0] bwe,
    output op_e           issue_op,
    output op_e           c_op,
    output logic [AW-1:0] c_addr,
    output logic [NB-1:0] c_ben
);

    logic          sel_all;
    op_e           last_q;
    logic [AW-1:0] base_q, n_base, n_addr;
    logic [1:0]    cnt_q, n_cnt;

    assign sel_all = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        issue_op = OP_NONE;
        n_base   = base_q;
        n_cnt    = cnt_q;
        if (!sleep) begin
            if (adv) begin
                if (last_q != OP_NONE) begin
                    issue_op = last_q;
                    n_cnt    = cnt_q + 2'd1;
                end
            end else if (sel_all) begin
                issue_op = wr_sel ? OP_WR : OP_RD;
                n_base   = addr;
                n_cnt    = 2'd0;
            end
        end
        n_addr = {n_base[AW-1:2], burst_low(n_base[1:0], n_cnt, burst_ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= OP_NONE;
            base_q <= '0;
            cnt_q  <= '0;
            c_op   <= OP_NONE;
            c_addr <= '0;
            c_ben  <= '0;
        end else begin
            last_q <= issue_op;
            base_q <= n_base;
            cnt_q  <= n_cnt;
            c_op   <= issue_op;
            c_addr <= n_addr;
            c_ben  <= bwe;
        end
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !sel_all) |=> (c_op == OP_NONE)) else $error("deselect issued a command");  // R1
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (c_op == OP_NONE)) else $error("command issued in sleep");  // R11
    AST_BURST_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adv && last_q != OP_NONE) |=> (c_addr[AW-1:2] == $past(c_addr[AW-1:2]))) else $error("burst left its block");  // R8
    AST_ADV_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adv && last_q == OP_NONE) |=> (c_op == OP_NONE)) else $error("advance without a burst");  // R13

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_ben,
    input  logic [NB*BW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_ben[b]) begin
                lane_mem[wr_addr] <= wr_data[b*BW +: BW];
            end
        end

        assign rd_data[b*BW +: BW] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/lwsram_wpath.sv
module lwsram_wpath
    import lwsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flow_mode,
    input  op_e           c_op,
    input  logic [AW-1:0] c_addr,
    input  logic [NB-1:0] c_ben,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [NB-1:0] wr_ben,
    output logic          byp_valid,
    output logic [AW-1:0] byp_addr,
    output logic [NB-1:0] byp_ben
);

    op_e           d1_op;
    logic [AW-1:0] d1_addr;
    logic [NB-1:0] d1_ben;

    // Second delay stage, used only by the pipelined (double late) write
    always_ff @(posedge clk) begin
        if (rst) begin
            d1_op   <= OP_NONE;
            d1_addr <= '0;
            d1_ben  <= '0;
        end else begin
            d1_op   <= c_op;
            d1_addr <= c_addr;
            d1_ben  <= c_ben;
        end
    end

    assign wr_en   = flow_mode ? (c_op == OP_WR) : (d1_op == OP_WR);
    assign wr_addr = flow_mode ? c_addr : d1_addr;
    assign wr_ben  = flow_mode ? c_ben  : d1_ben;

    // In-flight write whose data sits on din this cycle (pipelined only)
    assign byp_valid = !flow_mode && (d1_op == OP_WR);
    assign byp_addr  = d1_addr;
    assign byp_ben   = d1_ben;

endmodule

// File: rtl/lwsram_rpath.sv
module lwsram_rpath
    import lwsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flow_mode,
    input  op_e              c_op,
    input  logic [AW-1:0]    c_addr,
    input  logic [NB*BW-1:0] arr_q,
    input  logic             byp_valid,
    input  logic [AW-1:0]    byp_addr,
    input  logic [NB-1:0]    byp_ben,
    input  logic [NB*BW-1:0] din,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [NB*BW-1:0] dout,
    output logic             dout_vld
);

    localparam int DW = NB * BW;

    logic          hit, q_vld, rd_vld, drive;
    logic [DW-1:0] merged, q_data, rd_data;

    assign hit = byp_valid && (byp_addr == c_addr);

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*BW +: BW] = (hit && byp_ben[b]) ? din[b*BW +: BW]
                                                        : arr_q[b*BW +: BW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_data <= '0;
        end else begin
            q_vld  <= (c_op == OP_RD);
            q_data <= merged;
        end
    end

    assign rd_data  = flow_mode ? arr_q : q_data;
    assign rd_vld   = flow_mode ? (c_op == OP_RD) : q_vld;
    assign drive    = !oe_n && !sleep;
    assign dout     = (drive && rd_vld) ? rd_data : '0;
    assign dout_vld = drive && rd_vld;

    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dout == '0 && !dout_vld)) else $error("outputs on with oe_n high");  // R10
    AST_FLOW_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (flow_mode && !oe_n && !sleep && c_op == OP_RD) |-> dout_vld) else $error("flow read not shown");  // R2
    AST_PIPE_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
        (!flow_mode && dout_vld) |-> ($past(c_op) == OP_RD)) else $error("pipelined data without read");  // R3

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flow_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_sel,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    adv,
    input  logic                    burst_ilv,
    input  logic [BYTES-1:0]        bwe,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_vld
);

    localparam int DW = BYTES * BYTE_W;

    op_e               issue_op, c_op;
    logic [ADDR_W-1:0] c_addr, wr_addr, byp_addr;
    logic [BYTES-1:0]  c_ben, wr_ben, byp_ben;
    logic              wr_en, byp_valid;
    logic [DW-1:0]     arr_q;

    lwsram_cmd #(.AW(ADDR_W), .NB(BYTES)) u_cmd (
        .clk(clk), .rst(rst), .addr(addr), .wr_sel(wr_sel),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .adv(adv), .burst_ilv(burst_ilv), .sleep(sleep), .bwe(bwe),
        .issue_op(issue_op), .c_op(c_op), .c_addr(c_addr), .c_ben(c_ben)
    );

    lwsram_wpath #(.AW(ADDR_W), .NB(BYTES)) u_wpath (
        .clk(clk), .rst(rst), .flow_mode(flow_mode),
        .c_op(c_op), .c_addr(c_addr), .c_ben(c_ben),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_ben(wr_ben),
        .byp_valid(byp_valid), .byp_addr(byp_addr), .byp_ben(byp_ben)
    );

    lwsram_array #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_ben(wr_ben),
        .wr_data(din), .rd_addr(c_addr), .rd_data(arr_q)
    );

    lwsram_rpath #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_rpath (
        .clk(clk), .rst(rst), .flow_mode(flow_mode),
        .c_op(c_op), .c_addr(c_addr), .arr_q(arr_q),
        .byp_valid(byp_valid), .byp_addr(byp_addr), .byp_ben(byp_ben),
        .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_vld(dout_vld)
    );

    AST_LATE_WRITE_DELAY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (flow_mode ? ($past(issue_op) == OP_WR)
                             : ($past(issue_op, 2) == OP_WR))) else $error("write data slot misaligned");  // R5

endmodule

// File: tb/lwsram_core_tb.sv
`timescale 1ns/1ps
module lwsram_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flow_mode = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_sel = 1'b0;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        adv = 1'b0, burst_ilv = 1'b0;
    logic [3:0]  bwe = '0;
    logic [35:0] din = '0;
    logic        oe_n = 1'b0, sleep = 1'b0;
    logic [35:0] dout;
    logic        dout_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [35:0] model [64];

    localparam int K_NOP = 0, K_RD = 1, K_WR = 2, K_ADV = 3;

    lwsram_core u_dut (
        .clk(clk), .rst(rst), .flow_mode(flow_mode), .addr(addr), .wr_sel(wr_sel),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv),
        .burst_ilv(burst_ilv), .bwe(bwe), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_vld(dout_vld)
    );

    always #4 clk = ~clk;

    function automatic logic [35:0] merge(input logic [35:0] old_v, input logic [35:0] new_v,
                                          input logic [3:0] ben);
        logic [35:0] r = old_v;
        for (int b = 0; b < 4; b++) if (ben[b]) r[b*9 +: 9] = new_v[b*9 +: 9];
        return r;
    endfunction

    function automatic logic [5:0] beat(input logic [5:0] s, input int n, input logic ilv);
        logic [1:0] st = 2'(n);
        return {s[5:2], ilv ? (s[1:0] ^ st) : (s[1:0] + st)};
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // en: bit0 sel_a_n active, bit1 sel_b active, bit2 sel_c_n active
    task automatic cyc(input int kind, input logic [5:0] a, input logic [3:0] b,
                       input logic [35:0] d, input logic [2:0] en);
        logic cmd = (kind == K_RD) || (kind == K_WR);
        addr    = a;
        bwe     = b;
        din     = d;
        adv     = (kind == K_ADV);
        wr_sel  = (kind == K_WR);
        sel_a_n = !(cmd && en[0]);
        sel_b   = cmd && en[1];
        sel_c_n = !(cmd && en[2]);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop(input logic [35:0] d);
        cyc(K_NOP, 6'd0, 4'd0, d, 3'b111);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        flow_mode = mode;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_single(input logic [5:0] a, input logic [3:0] b, input logic [35:0] d);
        int lat = flow_mode ? 1 : 2;
        cyc(K_WR, a, b, 36'h0, 3'b111);
        for (int i = 1; i <= lat; i++) nop((i == lat) ? d : 36'h0);
        model[a] = merge(model[a], d, b);
    endtask

    task automatic rd_check(input logic [5:0] a, input string tag);
        cyc(K_RD, a, 4'h0, 36'h0, 3'b111);
        if (!flow_mode) nop(36'h0);
        chk({tag, " vld"}, 36'(dout_vld), 36'h1);
        chk({tag, " data"}, dout, model[a]);
    endtask

    task automatic t_flow;
        do_reset(1'b1);
        chk("R12 reset vld", 36'(dout_vld), 36'h0);
        wr_single(6'd5, 4'hF, 36'h1_1111_1111);
        rd_check(6'd5, "R2 R4 flow write then read");
        cyc(K_WR, 6'd6, 4'hF, 36'h0, 3'b111);
        cyc(K_RD, 6'd6, 4'h0, 36'h2_2222_2222, 3'b111);
        model[6] = 36'h2_2222_2222;
        chk("R6 flow read right after write", dout, model[6]);
        cyc(K_WR, 6'd5, 4'b0011, 36'h0, 3'b111);
        cyc(K_RD, 6'd5, 4'h0, 36'h3_3333_3333, 3'b111);
        model[5] = merge(model[5], 36'h3_3333_3333, 4'b0011);
        chk("R7 flow byte merge", dout, model[5]);
    endtask

    task automatic t_pipe_basic;
        do_reset(1'b0);
        chk("R12 reset vld", 36'(dout_vld), 36'h0);
        chk("R12 reset dout", dout, 36'h0);
        wr_single(6'd7, 4'hF, 36'h0_AAAA_5555);
        cyc(K_RD, 6'd7, 4'h0, 36'h0, 3'b111);
        chk("R3 not valid one edge early", 36'(dout_vld), 36'h0);
        nop(36'h0);
        chk("R3 R5 pipelined read data", dout, model[7]);
        // in-flight partial write hit by the next read
        cyc(K_WR, 6'd7, 4'b0101, 36'h0, 3'b111);
        cyc(K_RD, 6'd7, 4'h0, 36'h0, 3'b111);
        nop(36'h9_8765_4321);
        model[7] = merge(model[7], 36'h9_8765_4321, 4'b0101);
        chk("R6 R7 pipelined in-flight merge", dout, model[7]);
        rd_check(6'd7, "R7 merged word in array");
    endtask

    task automatic t_rwr;
        wr_single(6'd41, 4'hF, 36'h0_4141_4141);
        cyc(K_WR, 6'd40, 4'hF, 36'h0, 3'b111);
        cyc(K_RD, 6'd41, 4'h0, 36'h0, 3'b111);
        cyc(K_WR, 6'd42, 4'hF, 36'h4_0404_0404, 3'b111);
        model[40] = 36'h4_0404_0404;
        chk("R6 read between writes", dout, model[41]);
        cyc(K_RD, 6'd40, 4'h0, 36'h0, 3'b111);
        nop(36'h4_2424_2424);
        model[42] = 36'h4_2424_2424;
        chk("R6 read after write back to back", dout, model[40]);
        rd_check(6'd42, "R5 second write committed");
    endtask

    task automatic t_burst(input logic ilv, input logic [5:0] start, input string tag);
        burst_ilv = ilv;
        for (int i = 0; i < 4; i++)
            wr_single({start[5:2], 2'(i)}, 4'hF, 36'h5_0000_0000 + 36'(start) * 16 + 36'(i));
        cyc(K_RD, start, 4'h0, 36'h0, 3'b111);
        for (int i = 1; i <= 4; i++) begin
            cyc(K_ADV, 6'd0, 4'h0, 36'h0, 3'b111);
            chk({tag, " beat"}, dout, model[beat(start, i - 1, ilv)]);
        end
        nop(36'h0);
        chk({tag, " wrap to start"}, dout, model[start]);
        burst_ilv = 1'b0;
    endtask

    task automatic t_enables;
        logic [2:0] pats [3] = '{3'b110, 3'b101, 3'b011};
        wr_single(6'd20, 4'hF, 36'h2_0202_0202);
        foreach (pats[i]) begin
            cyc(K_WR, 6'd20, 4'hF, 36'h0, pats[i]);
            nop(36'hF_FFFF_FFFF);
            nop(36'hF_FFFF_FFFF);
            rd_check(6'd20, "R1 deselected write ignored");
            cyc(K_RD, 6'd20, 4'h0, 36'h0, pats[i]);
            nop(36'h0);
            chk("R1 deselected read no data", 36'(dout_vld), 36'h0);
        end
    endtask

    task automatic t_sleep_oe;
        wr_single(6'd30, 4'hF, 36'h3_0303_0303);
        sleep = 1'b1;
        cyc(K_WR, 6'd30, 4'hF, 36'h0, 3'b111);
        nop(36'hE_EEEE_EEEE);
        nop(36'hE_EEEE_EEEE);
        sleep = 1'b0;
        rd_check(6'd30, "R11 command in sleep ignored");
        sleep = 1'b1;
        #1;
        chk("R11 sleep drops vld", 36'(dout_vld), 36'h0);
        sleep = 1'b0;
        #1;
        chk("R11 contents kept", dout, model[30]);
        oe_n = 1'b1;
        #1;
        chk("R10 oe_n off data", dout, 36'h0);
        chk("R10 oe_n off vld", 36'(dout_vld), 36'h0);
        oe_n = 1'b0;
        #1;
        chk("R10 oe_n restored", dout, model[30]);
    endtask

    task automatic t_adv_idle;
        nop(36'h0);
        cyc(K_ADV, 6'd30, 4'h0, 36'h0, 3'b111);
        nop(36'h0);
        chk("R13 advance after deselect", 36'(dout_vld), 36'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_flow();
        t_pipe_basic();
        t_rwr();
        t_burst(1'b0, 6'd10, "R8 linear");
        t_burst(1'b1, 6'd13, "R9 interleaved");
        t_enables();
        t_sleep_oe();
        t_adv_idle();
        finish_run();
    end

endmodule